// File: doc/BRIEF.md
# NAND Chunk Hamming ECC Engine

This engine builds a single-error-correcting parity code over one NAND data chunk (512 bytes by default) while the bytes stream past, one byte per clock. For every bit of the chunk, its position is the byte index times eight plus the bit index, a 12-bit number. One 12-bit parity group collects the positions of set data bits where a given position bit is one, and a second group collects those where it is zero. The two groups are packed into a 24-bit code and inverted, so a chunk of all 0xFF bytes (an erased page) yields an all-ones code that matches unprogrammed spare bytes.

Several chip-select contexts accumulate independently. A start pulse clears a context and arms it. A take pulse sends that context's code out as three bytes, least significant first, for writing to the spare area, and clears the context. On read-back, the stored code is presented with a check pulse. The engine XORs it with the freshly computed code and reports one of four outcomes one cycle later: no error, a correctable data bit (with its byte and bit index), a hit in the stored code itself, or uncorrectable.

Top module: `nand_ecc1_engine`

## Requirements
- R1: While reset is high, and after it, every context is idle and empty: `code_o` reads 0xFFFFFF, `code_byte_vld_o` is 0 and `done_o` is 0.
- R2: `code_o` shows the selected context's code at once. Bits 23:12 are the inverted "odd" group and bits 11:0 the inverted "even" group. Odd bit k is the XOR of the data bits whose position (byte order after start times 8 plus the bit number) has bit k set. Even bit k uses the positions where bit k is clear.
- R3: A full chunk of 0xFF bytes gives the code 0xFFFFFF.
- R4: Bytes are ignored by a context that is not armed, or that has already taken CHUNK_BYTES bytes since its start. Its code stays unchanged.
- R5: Contexts are independent: bytes and commands reach only the context named by `cs_i`. A start clears and arms the context, and a byte sent in the same cycle as the start is dropped.
- R6: A take, when no code is being emitted, places the code on `code_byte_o` in the next three cycles, bits 7:0 first, with `code_byte_vld_o` high. The context is then cleared and disarmed. A take that arrives while bytes are still being emitted has no effect.
- R7: `done_o` is high in the cycle after each `chk_i`, and only then. It reports status 0 (no error) when the stored and computed codes are equal.
- R8: When the upper 12 bits of the difference XOR its lower 12 bits equal 0xFFF, the status is 1 (corrected). `err_byte_o` is then difference bits 23:15 and `err_bit_o` is difference bits 14:12.
- R9: A difference that passes the R8 test but names a byte index at or above CHUNK_BYTES gets status 3 (uncorrectable).
- R10: A difference with exactly one bit set gets status 2 (the stored code is hit and the data is good), and the indices read 0.
- R11: Any other nonzero difference gets status 3, and the indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | CS_W | Context addressed by every command and byte |
| start_i | input | 1 | Clear and arm the addressed context |
| byte_vld_i | input | 1 | A data byte is present |
| byte_i | input | 8 | Data byte |
| take_i | input | 1 | Emit the addressed code and clear the context |
| chk_i | input | 1 | Compare the stored code with the addressed code |
| stored_code_i | input | 24 | Code read back from the spare area |
| code_o | output | 24 | Live code of the addressed context |
| code_byte_o | output | 8 | Emitted code byte |
| code_byte_vld_o | output | 1 | Emitted byte valid |
| done_o | output | 1 | Classification result valid |
| status_o | output | 2 | 0 none, 1 corrected, 2 code hit, 3 uncorrectable |
| err_byte_o | output | 9 | Byte index of the corrected bit |
| err_bit_o | output | 3 | Bit index of the corrected bit |

## Verification
A corrupted parity group or byte counter shows on `code_o` in the same cycle, because that port reads the addressed context without a register in between. A reference model compares the port with the expected code after every clock. A wrong emitter count shows at the first byte slot, where a byte is missing, extra or shifted. A classifier fault appears in the `done_o` cycle, one clock after the check. Checks at the chunk-size boundary and a second instance with a shorter chunk expose an off-by-one in the counter limit or in the index range test.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = 3;
    localparam int LINE_W     = 9;
    localparam int POS_W      = LINE_W + BIT_IDX_W;
    localparam int CODE_W     = 2 * POS_W;
    localparam int CODE_BYTES = CODE_W / BYTE_W;
    localparam int RAW_W      = 32;
    localparam int RAW_HI_LSB = 16;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RAW_W-1:0]  raw_t;

    // odd_par: positions with the bit set; even_par: positions with it clear
    typedef struct packed {
        pos_t odd_par;
        pos_t even_par;
    } par_pair_t;

    typedef enum logic [1:0] {
        ECC_CLEAN    = 2'd0,
        ECC_FIXABLE  = 2'd1,
        ECC_CODE_HIT = 2'd2,
        ECC_FATAL    = 2'd3
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e            status;
        logic [LINE_W-1:0]      byte_idx;
        logic [BIT_IDX_W-1:0]   bit_idx;
    } ecc_report_t;

    // Parity contribution of one byte placed at a given line
    function automatic par_pair_t byte_delta(input logic [LINE_W-1:0] line,
                                             input logic [BYTE_W-1:0] d);
        par_pair_t r;
        pos_t      p;
        r = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            p = {line, BIT_IDX_W'(b)};
            if (d[b]) begin
                r.odd_par  = r.odd_par ^ p;
                r.even_par = r.even_par ^ ~p;
            end
        end
        return r;
    endfunction

    // Hardware-style raw word: even group low, odd group at bit 16
    function automatic raw_t to_raw(input par_pair_t pp);
        raw_t r;
        r = '0;
        r[POS_W-1:0]             = pp.even_par;
        r[RAW_HI_LSB +: POS_W]   = pp.odd_par;
        return r;
    endfunction

    // Pack both groups into the stored layout and invert
    function automatic code_t pack_code(input raw_t r);
        return ~{r[RAW_HI_LSB +: POS_W], r[POS_W-1:0]};
    endfunction

endpackage

// File: rtl/ecc1_accum.sv
module ecc1_accum
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              take_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output raw_t              raw_o
);
    localparam int CNT_W = $clog2(CHUNK_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CHUNK_BYTES);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    par_pair_t        pair_q;
    par_pair_t        delta;
    logic             accept;

    assign accept = byte_vld_i && run_q && (cnt_q < CNT_LIMIT);
    assign delta  = byte_delta(LINE_W'(cnt_q), byte_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            pair_q <= '0;
        end else if (start_i) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            pair_q <= '0;
        end else if (take_i) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            pair_q <= '0;
        end else if (accept) begin
            pair_q <= pair_q ^ delta;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign raw_o = to_raw(pair_q);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LIMIT);

    // R4
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (raw_o == '0));

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (run_q && cnt_q == '0 && raw_o == '0));

endmodule

// File: rtl/ecc1_code_ser.sv
module ecc1_code_ser
    import nand_ecc1_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  code_t             code_i,
    output logic              busy_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o
);
    localparam int CNT_W = $clog2(CODE_BYTES + 1);

    logic [CNT_W-1:0] left_q;
    code_t            sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            sh_q   <= '0;
        end else if (left_q != '0) begin
            sh_q   <= sh_q >> BYTE_W;
            left_q <= left_q - 1'b1;
        end else if (load_i) begin
            sh_q   <= code_i;
            left_q <= CNT_W'(CODE_BYTES);
        end
    end

    assign busy_o = (left_q != '0);
    assign vld_o  = busy_o;
    assign byte_o = sh_q[BYTE_W-1:0];

    // R6
    ser_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vld_o) |-> $past(load_i));

endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
)
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_i,
    input  code_t       stored_i,
    input  code_t       calc_i,
    output logic        done_o,
    output ecc_report_t report_o
);
    localparam logic [LINE_W:0] IDX_LIMIT = (LINE_W + 1)'(CHUNK_BYTES);

    code_t             diff;
    pos_t              hi;
    pos_t              lo;
    logic [LINE_W-1:0] line_idx;
    ecc_report_t       rep_n;
    ecc_report_t       rep_q;
    logic              done_q;

    assign diff     = stored_i ^ calc_i;
    assign hi       = diff[CODE_W-1:POS_W];
    assign lo       = diff[POS_W-1:0];
    assign line_idx = hi[POS_W-1:BIT_IDX_W];

    always_comb begin
        rep_n        = '0;
        rep_n.status = ECC_CLEAN;
        if (diff == '0) begin
            rep_n.status = ECC_CLEAN;
        end else if ((hi ^ lo) == {POS_W{1'b1}}) begin
            if ({1'b0, line_idx} < IDX_LIMIT) begin
                rep_n.status   = ECC_FIXABLE;
                rep_n.byte_idx = line_idx;
                rep_n.bit_idx  = hi[BIT_IDX_W-1:0];
            end else begin
                rep_n.status = ECC_FATAL;
            end
        end else if ($onehot(diff)) begin
            rep_n.status = ECC_CODE_HIT;
        end else begin
            rep_n.status = ECC_FATAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            rep_q  <= '0;
        end else begin
            done_q <= chk_i;
            if (chk_i) begin
                rep_q <= rep_n;
            end
        end
    end

    assign done_o   = done_q;
    assign report_o = rep_q;

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(chk_i));

    // R7
    clean_match_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && report_o.status == ECC_CLEAN) |-> $past(stored_i == calc_i));

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && report_o.status == ECC_FIXABLE) |-> ({1'b0, report_o.byte_idx} < IDX_LIMIT));

    // R10
    code_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && report_o.status == ECC_CODE_HIT) |-> $past($countones(stored_i ^ calc_i) == 1));

endmodule

// File: rtl/nand_ecc1_engine.sv
module nand_ecc1_engine
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int NUM_CS      = 4,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
)
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CS_W-1:0]      cs_i,
    input  logic                 start_i,
    input  logic                 byte_vld_i,
    input  logic [BYTE_W-1:0]    byte_i,
    input  logic                 take_i,
    input  logic                 chk_i,
    input  logic [CODE_W-1:0]    stored_code_i,
    output logic [CODE_W-1:0]    code_o,
    output logic [BYTE_W-1:0]    code_byte_o,
    output logic                 code_byte_vld_o,
    output logic                 done_o,
    output logic [1:0]           status_o,
    output logic [LINE_W-1:0]    err_byte_o,
    output logic [BIT_IDX_W-1:0] err_bit_o
);
    raw_t        raw_arr [NUM_CS];
    raw_t        sel_raw;
    logic        ser_busy;
    logic        take_ok;
    ecc_report_t report;

    assign take_ok = take_i && !ser_busy;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ctx
        logic hit;
        assign hit = (cs_i == CS_W'(g));
        ecc1_accum #(
            .CHUNK_BYTES (CHUNK_BYTES)
        ) i_accum (
            .clk        (clk),
            .rst        (rst),
            .start_i    (start_i && hit),
            .take_i     (take_ok && hit),
            .byte_vld_i (byte_vld_i && hit),
            .byte_i     (byte_i),
            .raw_o      (raw_arr[g])
        );
    end

    always_comb begin
        sel_raw = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs_i == CS_W'(i)) begin
                sel_raw = raw_arr[i];
            end
        end
    end

    assign code_o = pack_code(sel_raw);

    ecc1_code_ser i_ser (
        .clk    (clk),
        .rst    (rst),
        .load_i (take_ok),
        .code_i (code_o),
        .busy_o (ser_busy),
        .byte_o (code_byte_o),
        .vld_o  (code_byte_vld_o)
    );

    ecc1_classify #(
        .CHUNK_BYTES (CHUNK_BYTES)
    ) i_cls (
        .clk      (clk),
        .rst      (rst),
        .chk_i    (chk_i),
        .stored_i (stored_code_i),
        .calc_i   (code_o),
        .done_o   (done_o),
        .report_o (report)
    );

    assign status_o   = report.status;
    assign err_byte_o = report.byte_idx;
    assign err_bit_o  = report.bit_idx;

endmodule

// File: tb/test_nand_ecc1_engine.sv
`timescale 1ns/1ps
module test_nand_ecc1_engine;

    localparam int CHUNK = 512;
    localparam int SHORT_CHUNK = 384;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cs;
    logic        start, bvld, take, chk;
    logic [7:0]  bdata;
    logic [23:0] stored;
    logic [23:0] code;
    logic [7:0]  cbyte;
    logic        cvld, done;
    logic [1:0]  status;
    logic [8:0]  ebyte;
    logic [2:0]  ebit;

    logic        s_start, s_chk;
    logic [23:0] s_stored;
    logic [23:0] s_code;
    logic [7:0]  s_cbyte;
    logic        s_cvld, s_done;
    logic [1:0]  s_status;
    logic [8:0]  s_ebyte;
    logic [2:0]  s_ebit;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nand_ecc1_engine #(.CHUNK_BYTES(CHUNK), .NUM_CS(4)) i_nand_ecc1_engine (
        .clk(clk), .rst(rst), .cs_i(cs), .start_i(start), .byte_vld_i(bvld),
        .byte_i(bdata), .take_i(take), .chk_i(chk), .stored_code_i(stored),
        .code_o(code), .code_byte_o(cbyte), .code_byte_vld_o(cvld),
        .done_o(done), .status_o(status), .err_byte_o(ebyte), .err_bit_o(ebit)
    );

    nand_ecc1_engine #(.CHUNK_BYTES(SHORT_CHUNK), .NUM_CS(4)) i_nand_ecc1_engine_short (
        .clk(clk), .rst(rst), .cs_i(2'd0), .start_i(s_start), .byte_vld_i(1'b0),
        .byte_i(8'd0), .take_i(1'b0), .chk_i(s_chk), .stored_code_i(s_stored),
        .code_o(s_code), .code_byte_o(s_cbyte), .code_byte_vld_o(s_cvld),
        .done_o(s_done), .status_o(s_status), .err_byte_o(s_ebyte), .err_bit_o(s_ebit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_odd [4];
    int m_even[4];
    int m_cnt [4];
    bit m_run [4];
    byte unsigned q[$];
    bit e_done;
    int e_st, e_by, e_bi;
    string e_tag;

    function automatic int m_code(input int c);
        return (~((m_odd[c] << 12) | m_even[c])) & 'hFFFFFF;
    endfunction

    function automatic int data_diff(input int by, input int bi);
        int p;
        p = by * 8 + bi;
        return ((p & 'hFFF) << 12) | ((~p) & 'hFFF);
    endfunction

    task automatic classify(input int diff, input int lim,
                            output int st, output int by, output int bi, output string tg);
        int hi, lo;
        hi = (diff >> 12) & 'hFFF;
        lo = diff & 'hFFF;
        st = 0; by = 0; bi = 0; tg = "R7";
        if (diff == 0) begin
            st = 0; tg = "R7";
        end else if ((hi ^ lo) == 'hFFF) begin
            if ((hi >> 3) < lim) begin
                st = 1; by = hi >> 3; bi = hi & 7; tg = "R8";
            end else begin
                st = 3; tg = "R9";
            end
        end else if ($countones(diff) == 1) begin
            st = 2; tg = "R10";
        end else begin
            st = 3; tg = "R11";
        end
    endtask

    int  mc, snap, pos;
    bit  busy, tk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_odd[i] = 0; m_even[i] = 0; m_cnt[i] = 0; m_run[i] = 0;
            end
            q.delete();
            e_done = 0;
        end else begin
            mc   = int'(cs);
            snap = m_code(mc);
            busy = (q.size() != 0);
            tk   = take && !busy;
            if (chk) begin
                e_done = 1;
                classify(int'(stored) ^ snap, CHUNK, e_st, e_by, e_bi, e_tag);
            end else begin
                e_done = 0;
            end
            if (busy) void'(q.pop_front());
            if (tk) begin
                q.push_back(byte'(snap & 'hFF));
                q.push_back(byte'((snap >> 8) & 'hFF));
                q.push_back(byte'((snap >> 16) & 'hFF));
            end
            if (start) begin
                m_odd[mc] = 0; m_even[mc] = 0; m_cnt[mc] = 0; m_run[mc] = 1;
            end else if (tk) begin
                m_odd[mc] = 0; m_even[mc] = 0; m_cnt[mc] = 0; m_run[mc] = 0;
            end else if (bvld && m_run[mc] && m_cnt[mc] < CHUNK) begin
                for (int b = 0; b < 8; b++) begin
                    if (bdata[b]) begin
                        pos = m_cnt[mc] * 8 + b;
                        m_odd[mc]  = m_odd[mc] ^ pos;
                        m_even[mc] = m_even[mc] ^ ((~pos) & 'hFFF);
                    end
                end
                m_cnt[mc]++;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            check(code == 24'(m_code(int'(cs))), "R2", int'(code), m_code(int'(cs)));
            check(cvld == (q.size() != 0), "R6", int'(cvld), int'(q.size() != 0));
            if (q.size() != 0)
                check(cbyte == q[0], "R6", int'(cbyte), int'(q[0]));
            check(done == e_done, "R7", int'(done), int'(e_done));
            if (e_done) begin
                check(int'(status) == e_st, e_tag, int'(status), e_st);
                check(int'(ebyte) == e_by, e_tag, int'(ebyte), e_by);
                check(int'(ebit) == e_bi, e_tag, int'(ebit), e_bi);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit st, input int c, input bit v, input int d,
                       input bit tkk, input bit ck, input int sc);
        @(negedge clk);
        start = st; cs = 2'(c); bvld = v; bdata = 8'(d);
        take = tkk; chk = ck; stored = 24'(sc);
    endtask

    task automatic idle(input int c);
        cyc(0, c, 0, 0, 0, 0, 0);
    endtask

    task automatic short_chk(input int diff, input int exp_st, input int exp_by, input string tg);
        @(negedge clk);
        s_start = 1;
        @(negedge clk);
        s_start = 0; s_chk = 1; s_stored = 24'('hFFFFFF ^ diff);
        @(negedge clk);
        s_chk = 0;
        #1;
        check(s_done == 1'b1, tg, int'(s_done), 1);
        check(int'(s_status) == exp_st, tg, int'(s_status), exp_st);
        check(int'(s_ebyte) == exp_by, tg, int'(s_ebyte), exp_by);
    endtask

    int saved0;
    int diffs[10];

    initial begin
        rst = 1; start = 0; cs = 0; bvld = 0; bdata = 0; take = 0; chk = 0; stored = 0;
        s_start = 0; s_chk = 0; s_stored = 0;
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        check(code == 24'hFFFFFF, "R1", int'(code), 'hFFFFFF);
        check(cvld == 1'b0, "R1", int'(cvld), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        @(negedge clk);
        rst = 0;
        idle(0);
        #1;
        check(code == 24'hFFFFFF, "R1", int'(code), 'hFFFFFF);

        // cs0: full chunk of random bytes with gaps
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < CHUNK; i++) begin
            if (i % 7 == 3) idle(0);
            cyc(0, 0, 1, int'($urandom_range(0, 255)), 0, 0, 0);
        end
        idle(0);
        #1;
        saved0 = int'(code);
        // R4: bytes after a full chunk are ignored
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, int'($urandom_range(1, 255)), 0, 0, 0);
        idle(0);
        #1;
        check(int'(code) == saved0, "R4", int'(code), saved0);

        // cs1: erased chunk
        cyc(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < CHUNK; i++) cyc(0, 1, 1, 'hFF, 0, 0, 0);
        idle(1);
        #1;
        check(code == 24'hFFFFFF, "R3", int'(code), 'hFFFFFF);
        // R5: cs0 untouched by cs1 traffic
        idle(0);
        #1;
        check(int'(code) == saved0, "R5", int'(code), saved0);

        // R5: start wins over a byte in the same cycle
        cyc(1, 2, 1, 'h01, 0, 0, 0);
        idle(2);
        #1;
        check(code == 24'hFFFFFF, "R5", int'(code), 'hFFFFFF);
        cyc(0, 2, 1, 'h01, 0, 0, 0);
        idle(2);
        #1;
        check(code == 24'hFFF000, "R2", int'(code), 'hFFF000);

        // classification against cs0
        diffs[0] = 0;
        diffs[1] = data_diff(37, 5);
        diffs[2] = data_diff(511, 7);
        diffs[3] = data_diff(0, 0);
        diffs[4] = 'h000001;
        diffs[5] = 'h800000;
        diffs[6] = 'h001000;
        diffs[7] = 'h000003;
        diffs[8] = data_diff(3, 1) ^ data_diff(9, 4);
        diffs[9] = 'hFFFFFF;
        for (int i = 0; i < 10; i++) begin
            cyc(0, 0, 0, 0, 0, 1, saved0 ^ diffs[i]);
            if (i % 2 == 0) idle(0);
        end
        idle(0);
        idle(0);

        // R6: emit cs0, second take while busy is ignored
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        repeat (4) idle(0);
        #1;
        check(code == 24'hFFFFFF, "R6", int'(code), 'hFFFFFF);
        // R4: disarmed context ignores bytes
        cyc(0, 0, 1, 'h5A, 0, 0, 0);
        idle(0);
        #1;
        check(code == 24'hFFFFFF, "R4", int'(code), 'hFFFFFF);

        // R6: emit erased cs1 and cs2 back to back
        cyc(0, 1, 0, 0, 1, 0, 0);
        repeat (3) idle(1);
        cyc(0, 2, 0, 0, 1, 0, 0);
        repeat (5) idle(2);

        // short-chunk instance: index range
        short_chk(data_diff(400, 2), 3, 0, "R9");
        short_chk(data_diff(384, 0), 3, 0, "R9");
        short_chk(data_diff(383, 6), 1, 383, "R8");
        short_chk('h000400, 2, 0, "R10");

        repeat (3) idle(0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule